// File: doc/BRIEF.md
# UART Bit-Rate Generator

This block makes the timing strobes for a UART. A two-bit selector picks one of four count sources: every system clock cycle, every 8th cycle, every 32nd cycle, or each rising edge of an external clock pin. The chosen source decrements a reload counter that holds a programmed divisor n. Each time the counter passes zero it reloads from n and raises a one-cycle oversampling strobe for a receiver. A fixed divide-by-16 stage then turns every 16th oversampling strobe into a bit strobe for a transmitter. The result is a bit rate of source / (16 × (n + 1)). At 16 MHz, the divide-by-1 source with n = 103 gives 9615 bps. The divide-by-8 source with n = 207 gives 601 bps.

No derived clocks are made. The prescaler outputs are single-cycle enables in the system clock domain. The external pin passes through a two-flop synchroniser, and a third flop detects its rising edge. The divisor can be rewritten while the generator runs. The new value is used at the next reload. While the generator is disabled, a write loads the counter at once, so the first strobe after enable comes at a known time.

Top module: `uart_baud_gen`

## Requirements
- R1: With `src_sel` = 0 (every cycle), `tick16` pulses once every n+1 system clock cycles.
- R2: With `src_sel` = 1, `tick16` pulses once every 8·(n+1) system clock cycles.
- R3: With `src_sel` = 2, `tick16` pulses once every 32·(n+1) system clock cycles. This holds for the full 8-bit range of n, including 255.
- R4: `tick1` pulses together with every 16th `tick16` pulse and with no other, so its period is 16 times the `tick16` period.
- R5: With `src_sel` = 3, each rising edge of `ext_clk`, after synchronisation, counts once. `tick16` then pulses every n+1 external periods.
- R6: After reset, and for as long as `enable` is low, `tick16` and `tick1` stay low.
- R7: A divisor write while `enable` is high does not change the countdown in progress. The new value sets the period from the next reload on. A write in the same cycle as a reload takes effect one reload later.
- R8: A divisor write while `enable` is low loads the counter at once. With `src_sel` = 0, the first `tick16` then appears after the (n+1)-th rising clock edge at which `enable` is high.
- R9: `tick16` and `tick1` are each high for exactly one cycle whenever n is above 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator; low holds it idle |
| src_sel | input | 2 | Count source: 0 every cycle, 1 every 8th, 2 every 32nd, 3 external edges |
| div_wr | input | 1 | Write strobe for the divisor |
| div_val | input | CNT_W (8) | Divisor n |
| ext_clk | input | 1 | External count clock, asynchronous |
| tick16 | output | 1 | Oversampling strobe, one per counter underflow |
| tick1 | output | 1 | Bit strobe, one per 16 oversampling strobes |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, prescale taps at 8 and 32, and an oversampling ratio of 16. This puts both ends of the divisor range within reach in a short run. n = 0 makes a strobe every enabled cycle, and n = 255 with the divide-by-32 source gives the longest period, 8192 cycles. The measured strobe spacings are compared with the formula for each source. The bench also checks timed divisor rewrites, both while running and while idle. The external source is driven with a slow square wave so that the synchroniser delay does not blur the period.

// File: rtl/uart_brg_pkg.sv
package uart_brg_pkg;
    typedef enum logic [1:0] {
        SRC_DIV1 = 2'd0,
        SRC_DIVA = 2'd1,
        SRC_DIVB = 2'd2,
        SRC_EXT  = 2'd3
    } brg_src_e;
endpackage

// File: rtl/uart_brg_presc.sv
// Count-source selection: prescale taps and synchronised external edges,
// all delivered as single-cycle enables.
module uart_brg_presc
    import uart_brg_pkg::*;
#(
    parameter int PRE_A = 8,
    parameter int PRE_B = 32
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  brg_src_e sel,
    input  logic     ext_clk,
    output logic     src_en
);
    localparam int PA_W = $clog2(PRE_A);
    localparam int PB_W = $clog2(PRE_B);

    typedef struct packed {
        logic [PB_W-1:0] cnt;
        logic [2:0]      sync;
    } presc_s;

    presc_s d, q;
    logic   tap_a, tap_b, ext_edge;

    always_comb begin
        d      = q;
        d.sync = {q.sync[1:0], ext_clk};
        d.cnt  = enable ? q.cnt + 1'b1 : '0;
    end

    always_comb begin
        tap_a    = (q.cnt[PA_W-1:0] == {PA_W{1'b1}});
        tap_b    = (q.cnt == {PB_W{1'b1}});
        ext_edge = q.sync[1] & ~q.sync[2];
        unique case (sel)
            SRC_DIV1: src_en = enable;
            SRC_DIVA: src_en = enable & tap_a;
            SRC_DIVB: src_en = enable & tap_b;
            SRC_EXT:  src_en = enable & ext_edge;
            default:  src_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: a synchronised edge lasts one cycle, so no edge follows a counted one
    a_r5_ext_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en && sel == SRC_EXT) |=> !ext_edge);
endmodule

// File: rtl/uart_brg_reload.sv
// Reload down-counter holding divisor n; emits the oversampling strobe.
module uart_brg_reload #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             src_en,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic             tick16
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] n;
        logic             tick;
    } rld_s;

    rld_s d, q;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (wr) d.n = wdata;
        if (!enable) begin
            d.cnt = wr ? wdata : q.n;
        end else if (src_en) begin
            if (q.cnt == '0) begin
                d.cnt  = q.n;
                d.tick = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick16 = q.tick;

    // R8: an idle write lands in the counter at the next edge
    a_r8_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && wr) |=> (q.cnt == $past(wdata)));
    // R6: no strobe follows a cycle spent disabled
    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tick16);
    // R7: an underflow reloads the divisor held before any same-cycle write
    a_r7_reload_old_n: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && src_en && q.cnt == '0) |=> (q.cnt == $past(q.n)));
endmodule

// File: rtl/uart_brg_bitdiv.sv
// Divide the oversampling strobe down to the bit strobe.
module uart_brg_bitdiv #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick16,
    output logic tick1
);
    localparam int OVS_W = $clog2(OVS);

    typedef struct packed {
        logic [OVS_W-1:0] cnt;
    } bdiv_s;

    bdiv_s d, q;

    always_comb begin
        d = q;
        if (!enable)     d.cnt = '0;
        else if (tick16) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick1 = enable & tick16 & (q.cnt == OVS_W'(OVS - 1));

    // R9: the bit strobe is never high on two cycles in a row
    a_r9_tick1_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick1 |=> !tick1);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_brg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int OVS   = 16,
    parameter int PRE_A = 8,
    parameter int PRE_B = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       src_sel,
    input  logic             div_wr,
    input  logic [CNT_W-1:0] div_val,
    input  logic             ext_clk,
    output logic             tick16,
    output logic             tick1
);
    logic     src_en;
    brg_src_e sel;

    assign sel = brg_src_e'(src_sel);

    uart_brg_presc #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_presc (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sel(sel),
        .ext_clk(ext_clk), .src_en(src_en)
    );

    uart_brg_reload #(.CNT_W(CNT_W)) u_reload (
        .clk(clk), .rst_n(rst_n), .enable(enable), .src_en(src_en),
        .wr(div_wr), .wdata(div_val), .tick16(tick16)
    );

    uart_brg_bitdiv #(.OVS(OVS)) u_bitdiv (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .tick16(tick16), .tick1(tick1)
    );

    // R4: a bit strobe only ever coincides with an oversampling strobe
    a_r4_tick1_on_tick16: assert property (@(posedge clk) disable iff (!rst_n)
        tick1 |-> tick16);
endmodule

// File: tb/test_uart_baud_gen.sv
module test_uart_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       div_wr = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic       ext_clk = 1'b0;
    logic       ext_run = 1'b0;
    logic       tick16, tick1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    uart_baud_gen i_uart_baud_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
        .div_wr(div_wr), .div_val(div_val), .ext_clk(ext_clk),
        .tick16(tick16), .tick1(tick1)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  n;
        logic [15:0] gap;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 8'd0,   16'd1},
        '{2'd0, 8'd103, 16'd104},
        '{2'd0, 8'd33,  16'd34},
        '{2'd0, 8'd255, 16'd256},
        '{2'd1, 8'd4,   16'd40},
        '{2'd1, 8'd207, 16'd1664},
        '{2'd2, 8'd2,   16'd96},
        '{2'd2, 8'd255, 16'd8192}
    };

    // external clock: 3 cycles high, 3 low
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            if (ext_run) ext_clk = ~ext_clk;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic configure(input logic [1:0] sel, input logic [7:0] n);
        @(negedge clk);
        enable  = 1'b0;
        src_sel = sel;
        div_wr  = 1'b1;
        div_val = n;
        @(negedge clk);
        div_wr = 1'b0;
        enable = 1'b1;
    endtask

    // cycles until the next tick16 sample
    task automatic count_next(output int g);
        g = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            div_wr = 1'b0;
            g++;
            if (tick16) break;
        end
    endtask

    task automatic measure(output int g);
        int skip;
        count_next(skip);
        count_next(g);
    endtask

    initial begin
        int g;
        int cnt16;
        string tag;

        repeat (3) @(negedge clk);
        // R6: reset state
        check("R6 tick16 in reset", int'(tick16), 0);
        check("R6 tick1 in reset", int'(tick1), 0);
        rst_n = 1'b1;

        // R6: held disabled with the fastest setting
        @(negedge clk);
        src_sel = 2'd0;
        div_wr  = 1'b1;
        div_val = 8'd0;
        @(negedge clk);
        div_wr = 1'b0;
        cnt16 = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (tick16 || tick1) cnt16++;
        end
        check("R6 strobes while disabled", cnt16, 0);

        // R1, R2, R3: vector table
        foreach (VECS[k]) begin
            configure(VECS[k].sel, VECS[k].n);
            tag = (VECS[k].sel == 2'd0) ? "R1" : (VECS[k].sel == 2'd1) ? "R2" : "R3";
            measure(g);
            check($sformatf("%s period sel=%0d n=%0d", tag, VECS[k].sel, VECS[k].n),
                  g, int'(VECS[k].gap));
            count_next(g);
            check($sformatf("%s repeat sel=%0d n=%0d", tag, VECS[k].sel, VECS[k].n),
                  g, int'(VECS[k].gap));
        end

        // R8: idle write then first strobe after n+1 enabled edges
        configure(2'd0, 8'd5);
        count_next(g);
        check("R8 first tick after enable n=5", g, 6);
        configure(2'd0, 8'd0);
        count_next(g);
        check("R8 first tick after enable n=0", g, 1);

        // R9: one-cycle width
        configure(2'd0, 8'd4);
        count_next(g);
        @(negedge clk);
        check("R9 tick16 width", int'(tick16), 0);

        // R7: running write applies at next reload
        configure(2'd0, 8'd9);
        measure(g);
        check("R7 period before write", g, 10);
        div_wr  = 1'b1;
        div_val = 8'd4;
        count_next(g);
        check("R7 countdown in progress unchanged", g, 10);
        count_next(g);
        check("R7 new divisor after reload", g, 5);

        // R4: bit strobe
        configure(2'd0, 8'd2);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (tick1) break;
        end
        check("R4 tick16 with tick1", int'(tick16), 1);
        g = 0;
        cnt16 = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            g++;
            if (tick16) cnt16++;
            if (tick1) break;
        end
        check("R4 tick1 period", g, 48);
        check("R4 tick16 per tick1", cnt16, 16);
        @(negedge clk);
        check("R9 tick1 width", int'(tick1), 0);

        // R5: external source, 6-cycle period, n=3
        ext_run = 1'b1;
        configure(2'd3, 8'd3);
        measure(g);
        check("R5 external period", g, 24);
        count_next(g);
        check("R5 external repeat", g, 24);
        ext_run = 1'b0;

        // R6: disable stops strobes
        @(negedge clk);
        enable = 1'b0;
        cnt16 = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tick16 || tick1) cnt16++;
        end
        check("R6 strobes after disable", cnt16, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule